// File: doc/BRIEF.md
# Nonvolatile Write Unlock Controller

This block sits between the CPU's register bus and the programming engine of a nonvolatile program memory. It holds a control register and a 22-bit address pointer. A write or erase of the memory may begin only after software has sent a two-byte key to a key register that stores nothing. While the memory is being programmed, the block stalls the CPU. If a master-clear or watchdog reset arrives during programming, a sticky error flag records that the operation was cut short.

Software first loads the pointer and sets the enable bit. It then writes the key bytes 55h and AAh to the key register, in that order, and follows them at once with a control write that sets the start bit. The programming engine sees a level request and the target address, and it answers with a one-cycle done pulse. The start bit clears itself on that pulse.

Register addresses on the 3-bit bus are: 0 control, 1 key, 2 pointer bits 7:0, 3 pointer bits 15:8, 4 pointer bits 21:16 (in byte bits 5:0). Any other address reads zero.

Control register bit layout:

| Bit | Meaning |
|-----|---------|
| 0 | enable |
| 1 | start write |
| 2 | start read |
| 3 | erase select |
| 4 | error flag |
| 5 | configuration space |
| 6 | program space |
| 7 | reads zero |

Top module: `nvm_write_guard`

## Requirements
- R1: After a power-on reset (`rst`), the following all read 0: the control register, the three pointer bytes, `cpu_stall` and `mem_wr_req`.
- R2: The key register (address 1) always reads 0, including right after 55h has been written to it.
- R3: Four conditions start a write: the enable bit (control bit 0) is already 1, 55h is written to address 1, then AAh is written to address 1, and the very next bus access is a control write with bits 0 and 1 set. `cpu_stall` and `mem_wr_req` are then 1 from the next cycle, and `mem_addr` shows the pointer.
- R4: Each of the following disarms the key sequence, so that the following start request is ignored:
  - the key bytes arrive in the wrong order;
  - a key byte is repeated;
  - any bus read or write falls between the key bytes;
  - any bus read or write falls between the second key byte and the start write.
- R5: If the stored enable bit is 0, a start request is ignored and the key sequence is dropped. A start request repeated straight afterwards, with no new key, is also ignored.
- R6: Once a write has started, the start bit and `cpu_stall` stay 1 until `mem_done` is sampled high, and they are 0 in the cycle after that.
- R7: A `mclr_rst` or `wdt_rst` pulse during a write does three things: it clears `cpu_stall`, it sets the error flag (bit 4), and it clears every other control bit and the pointer. The error flag survives later warm resets.
- R8: A control write with bit 4 at 0 clears the error flag. A control write with bit 4 at 1 never sets it. A power-on reset clears it.
- R9: Pointer bit 21 (bit 5 of address 4) changes only when `test_mode` is 1; otherwise writes leave it unchanged. Bits 7:6 of address 4 read 0.
- R10: Control bits 3, 5 and 6 read back as written. They drive `mem_erase`, `mem_cfg_space` and `mem_prog_space`.
- R11: A control write with bit 2 set gives exactly one cycle of `mem_rd_req`, with no key needed. Bit 2 always reads 0.
- R12: While a write is in progress, bus writes change neither the pointer nor the control register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| mclr_rst | input | 1 | Master-clear warm reset, synchronous, active high |
| wdt_rst | input | 1 | Watchdog warm reset, synchronous, active high |
| test_mode | input | 1 | Allows writes to pointer bit 21 |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not reading |
| mem_wr_req | output | 1 | Programming request to the memory |
| mem_rd_req | output | 1 | One-cycle read request |
| mem_erase | output | 1 | Erase instead of write |
| mem_prog_space | output | 1 | Program memory selected |
| mem_cfg_space | output | 1 | Configuration space selected |
| mem_addr | output | 22 | Target address from the pointer |
| mem_done | input | 1 | Memory finished the operation |
| cpu_stall | output | 1 | CPU held while programming |

## Verification
The hardest state to reach is an aborted write. A warm reset has to land while a properly unlocked write is still waiting for `mem_done`. The error flag must then be shown to survive a second warm reset and to resist being set by software. The bench reaches this state by unlocking and starting a write, holding `mem_done` low, pulsing `mclr_rst` or `wdt_rst`, and then reading the control register across further resets. The disarm cases need accesses placed at exact points inside the key sequence: stray reads, repeated bytes and reversed bytes are each inserted at the one slot they should break.

// File: rtl/nvmg_pkg.sv
`timescale 1ns/1ps
package nvmg_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_KEY  = 3'd1;
    localparam int                A_PTR0 = 2;

    localparam logic [DATA_W-1:0] KEY_FIRST  = 8'h55;
    localparam logic [DATA_W-1:0] KEY_SECOND = 8'hAA;

    localparam int CB_WREN  = 0;
    localparam int CB_GO    = 1;
    localparam int CB_RD    = 2;
    localparam int CB_ERASE = 3;
    localparam int CB_ERR   = 4;
    localparam int CB_CFG   = 5;
    localparam int CB_PROG  = 6;

    // packed MSB first: layout matches the CB_* positions above
    typedef struct packed {
        logic pad;
        logic prog_space;
        logic cfg_space;
        logic err;
        logic erase;
        logic rd_go;
        logic wr_go;
        logic wr_en;
    } ctrl_t;

    typedef enum logic [1:0] {
        UL_IDLE  = 2'd0,
        UL_HALF  = 2'd1,
        UL_ARMED = 2'd2
    } unlock_e;

    function automatic logic [DATA_W-1:0] ctrl_view(input ctrl_t c);
        ctrl_t v;
        v       = c;
        v.rd_go = 1'b0;
        v.pad   = 1'b0;
        return v;
    endfunction

    function automatic int ptr_bytes(input int ptr_w, input int data_w);
        return (ptr_w + data_w - 1) / data_w;
    endfunction

endpackage

// File: rtl/nvmg_unlock.sv
`timescale 1ns/1ps
module nvmg_unlock
    import nvmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              wr_en_q,
    input  logic              busy,
    output logic              armed,
    output logic              start
);

    unlock_e state_q, state_d;
    logic    access;
    logic    key_wr;
    logic    ctrl_wr;

    assign access  = bus_wr | bus_rd;
    assign key_wr  = bus_wr && (bus_addr == A_KEY);
    assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
    assign armed   = (state_q == UL_ARMED);

    assign start = armed && ctrl_wr && !busy && wr_en_q
                   && bus_wdata[CB_GO] && bus_wdata[CB_WREN];

    always_comb begin
        state_d = state_q;
        if (busy) begin
            state_d = UL_IDLE;
        end else if (access) begin
            unique case (state_q)
                UL_IDLE:  state_d = (key_wr && bus_wdata == KEY_FIRST)  ? UL_HALF  : UL_IDLE;
                UL_HALF:  state_d = (key_wr && bus_wdata == KEY_SECOND) ? UL_ARMED : UL_IDLE;
                default:  state_d = UL_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || warm_rst) state_q <= UL_IDLE;
        else                 state_q <= state_d;
    end

endmodule

// File: rtl/nvmg_ctrl.sv
`timescale 1ns/1ps
module nvmg_ctrl
    import nvmg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              ctrl_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              start,
    input  logic              mem_done,
    output ctrl_t             ctrl_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (warm_rst) begin
            ctrl_q     <= '0;
            ctrl_q.err <= ctrl_q.err | ctrl_q.wr_go;
        end else begin
            ctrl_q.rd_go <= 1'b0;
            if (ctrl_q.wr_go) begin
                if (mem_done) ctrl_q.wr_go <= 1'b0;
            end else if (ctrl_wr) begin
                ctrl_q.wr_en      <= wdata[CB_WREN];
                ctrl_q.erase      <= wdata[CB_ERASE];
                ctrl_q.cfg_space  <= wdata[CB_CFG];
                ctrl_q.prog_space <= wdata[CB_PROG];
                ctrl_q.rd_go      <= wdata[CB_RD];
                ctrl_q.err        <= ctrl_q.err & wdata[CB_ERR];
                ctrl_q.wr_go      <= start;
            end
        end
    end

endmodule

// File: rtl/nvmg_ptr.sv
`timescale 1ns/1ps
module nvmg_ptr
    import nvmg_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              warm_rst,
    input  logic              wr_ok,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              test_mode,
    output logic [PTR_W-1:0]  ptr,
    output logic [ptr_bytes(PTR_W, DATA_W)*DATA_W-1:0] ptr_flat
);

    localparam int NB = ptr_bytes(PTR_W, DATA_W);
    localparam int PW = NB * DATA_W;

    logic [PW-1:0] bytes_q;
    logic [PW-1:0] wmask;
    logic [NB-1:0] hit;

    always_comb begin
        wmask = '0;
        for (int j = 0; j < PTR_W - 1; j++) wmask[j] = 1'b1;
        wmask[PTR_W-1] = test_mode;
    end

    for (genvar i = 0; i < NB; i++) begin : g_hit
        assign hit[i] = wr_ok && bus_wr && (bus_addr == ADDR_W'(A_PTR0 + i));
    end

    always_ff @(posedge clk) begin
        if (rst || warm_rst) begin
            bytes_q <= '0;
        end else begin
            for (int i = 0; i < NB; i++) begin
                if (hit[i]) begin
                    bytes_q[i*DATA_W +: DATA_W] <=
                        (bus_wdata & wmask[i*DATA_W +: DATA_W]) |
                        (bytes_q[i*DATA_W +: DATA_W] & ~wmask[i*DATA_W +: DATA_W]);
                end
            end
        end
    end

    assign ptr      = bytes_q[PTR_W-1:0];
    assign ptr_flat = bytes_q;

endmodule

// File: rtl/nvm_write_guard.sv
`timescale 1ns/1ps
module nvm_write_guard
    import nvmg_pkg::*;
#(
    parameter int PTR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mclr_rst,
    input  logic              wdt_rst,
    input  logic              test_mode,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              mem_wr_req,
    output logic              mem_rd_req,
    output logic              mem_erase,
    output logic              mem_prog_space,
    output logic              mem_cfg_space,
    output logic [PTR_W-1:0]  mem_addr,
    input  logic              mem_done,
    output logic              cpu_stall
);

    localparam int NB = ptr_bytes(PTR_W, DATA_W);

    ctrl_t                ctrl_q;
    logic                 warm_rst;
    logic                 busy;
    logic                 armed;
    logic                 start;
    logic                 ctrl_wr;
    logic [NB*DATA_W-1:0] ptr_flat;

    assign warm_rst = mclr_rst | wdt_rst;
    assign busy     = ctrl_q.wr_go;
    assign ctrl_wr  = bus_wr && (bus_addr == A_CTRL);

    nvmg_unlock u_unlock (
        .clk       (clk),
        .rst       (rst),
        .warm_rst  (warm_rst),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .wr_en_q   (ctrl_q.wr_en),
        .busy      (busy),
        .armed     (armed),
        .start     (start)
    );

    nvmg_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .warm_rst (warm_rst),
        .ctrl_wr  (ctrl_wr),
        .wdata    (bus_wdata),
        .start    (start),
        .mem_done (mem_done),
        .ctrl_q   (ctrl_q)
    );

    nvmg_ptr #(.PTR_W(PTR_W)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .warm_rst  (warm_rst),
        .wr_ok     (!busy),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .test_mode (test_mode),
        .ptr       (mem_addr),
        .ptr_flat  (ptr_flat)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            if (bus_addr == A_CTRL) bus_rdata = ctrl_view(ctrl_q);
            for (int i = 0; i < NB; i++) begin
                if (bus_addr == ADDR_W'(A_PTR0 + i)) bus_rdata = ptr_flat[i*DATA_W +: DATA_W];
            end
        end
    end

    assign mem_wr_req     = ctrl_q.wr_go;
    assign cpu_stall      = ctrl_q.wr_go;
    assign mem_rd_req     = ctrl_q.rd_go;
    assign mem_erase      = ctrl_q.erase;
    assign mem_prog_space = ctrl_q.prog_space;
    assign mem_cfg_space  = ctrl_q.cfg_space;

endmodule

// File: rtl/nvmg_checker.sv
`timescale 1ns/1ps
module nvmg_checker (
    input logic       clk,
    input logic       rst,
    input logic       mclr_rst,
    input logic       wdt_rst,
    input logic       test_mode,
    input logic       bus_rd,
    input logic [2:0] bus_addr,
    input logic [7:0] bus_rdata,
    input logic       cpu_stall,
    input logic       mem_done,
    input logic       mem_rd_req,
    input logic       err_q,
    input logic       wr_en_q,
    input logic       armed,
    input logic       ptr_top
);

    a_r2_key_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 3'd1) |-> (bus_rdata == 8'h00));

    a_r3_start_needs_arm: assert property (@(posedge clk) disable iff (rst)
        $rose(cpu_stall) |-> $past(armed));

    a_r5_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
        (!cpu_stall && !wr_en_q) |=> !cpu_stall);

    a_r6_hold_until_done: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && !mem_done && !mclr_rst && !wdt_rst) |=> cpu_stall);

    a_r6_release_on_done: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && mem_done) |=> !cpu_stall);

    a_r7_abort_sets_err: assert property (@(posedge clk) disable iff (rst)
        (cpu_stall && (mclr_rst || wdt_rst)) |=> (err_q && !cpu_stall));

    a_r9_top_bit_guard: assert property (@(posedge clk) disable iff (rst)
        $rose(ptr_top) |-> $past(test_mode));

    a_r11_read_pulse: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |=> !mem_rd_req);

endmodule

bind nvm_write_guard nvmg_checker u_nvmg_checker (
    .clk        (clk),
    .rst        (rst),
    .mclr_rst   (mclr_rst),
    .wdt_rst    (wdt_rst),
    .test_mode  (test_mode),
    .bus_rd     (bus_rd),
    .bus_addr   (bus_addr),
    .bus_rdata  (bus_rdata),
    .cpu_stall  (cpu_stall),
    .mem_done   (mem_done),
    .mem_rd_req (mem_rd_req),
    .err_q      (ctrl_q.err),
    .wr_en_q    (ctrl_q.wr_en),
    .armed      (armed),
    .ptr_top    (mem_addr[21])
);

// File: tb/test_nvm_write_guard.sv
`timescale 1ns/1ps
module test_nvm_write_guard;

    localparam int K_RDATA = 0;
    localparam int K_STALL = 1;
    localparam int K_WRREQ = 2;
    localparam int K_ADDR  = 3;
    localparam int K_ERASE = 4;
    localparam int K_RDREQ = 5;
    localparam int K_PROG  = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mclr_rst = 1'b0;
    logic        wdt_rst = 1'b0;
    logic        test_mode = 1'b0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        mem_wr_req, mem_rd_req, mem_erase, mem_prog_space, mem_cfg_space;
    logic [21:0] mem_addr;
    logic        mem_done = 1'b0;
    logic        cpu_stall;

    logic sample_req = 1'b0;
    int   n_cmp = 0;
    int   n_bad = 0;
    int   cycles = 0;
    bit   done = 1'b0;

    typedef struct {
        int          kind;
        logic [31:0] exp;
        string       tag;
    } exp_t;

    exp_t sb[$];

    always #4 clk = ~clk;

    nvm_write_guard i_nvm_write_guard (
        .clk(clk), .rst(rst), .mclr_rst(mclr_rst), .wdt_rst(wdt_rst),
        .test_mode(test_mode), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .mem_wr_req(mem_wr_req), .mem_rd_req(mem_rd_req), .mem_erase(mem_erase),
        .mem_prog_space(mem_prog_space), .mem_cfg_space(mem_cfg_space),
        .mem_addr(mem_addr), .mem_done(mem_done), .cpu_stall(cpu_stall)
    );

    // monitor: pops expected items and compares them mid-cycle
    always @(negedge clk) begin
        if (sample_req) begin
            exp_t        it;
            logic [31:0] act;
            if (sb.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard empty: actual none expected item");
            end else begin
                it = sb.pop_front();
                case (it.kind)
                    K_RDATA: act = {24'd0, bus_rdata};
                    K_STALL: act = {31'd0, cpu_stall};
                    K_WRREQ: act = {31'd0, mem_wr_req};
                    K_ADDR:  act = {10'd0, mem_addr};
                    K_ERASE: act = {31'd0, mem_erase};
                    K_RDREQ: act = {31'd0, mem_rd_req};
                    default: act = {31'd0, mem_prog_space};
                endcase
                n_cmp++;
                if (act !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.kind = K_RDATA; it.exp = {24'd0, e}; it.tag = tag;
        sb.push_back(it);
        bus_rd = 1'b1; bus_addr = a; sample_req = 1'b1;
        @(posedge clk); #1;
        bus_rd = 1'b0; sample_req = 1'b0;
    endtask

    task automatic probe(input int k, input logic [31:0] e, input string tag);
        exp_t it;
        it.kind = k; it.exp = e; it.tag = tag;
        sb.push_back(it);
        sample_req = 1'b1;
        @(posedge clk); #1;
        sample_req = 1'b0;
    endtask

    task automatic pulse_done();
        mem_done = 1'b1; @(posedge clk); #1; mem_done = 1'b0;
    endtask

    task automatic pulse_mclr();
        mclr_rst = 1'b1; @(posedge clk); #1; mclr_rst = 1'b0;
    endtask

    task automatic pulse_wdt();
        wdt_rst = 1'b1; @(posedge clk); #1; wdt_rst = 1'b0;
    endtask

    task automatic do_por();
        rst = 1'b1; repeat (3) @(posedge clk); #1; rst = 1'b0;
    endtask

    task automatic unlock_go(input logic [7:0] c);
        wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, c);
    endtask

    initial begin
        do_por();
        // R1 reset state
        rd_chk(3'd0, 8'h00, "R1 ctrl after reset");
        rd_chk(3'd2, 8'h00, "R1 ptr lo after reset");
        rd_chk(3'd4, 8'h00, "R1 ptr up after reset");
        probe(K_STALL, 0, "R1 stall after reset");
        probe(K_WRREQ, 0, "R1 wr req after reset");

        // R9 pointer bytes and guarded top bit
        wr(3'd2, 8'h34); wr(3'd3, 8'h12); wr(3'd4, 8'hFF);
        rd_chk(3'd4, 8'h1F, "R9 top bit blocked outside test mode");
        test_mode = 1'b1; wr(3'd4, 8'h3F);
        rd_chk(3'd4, 8'h3F, "R9 top bit written in test mode");
        test_mode = 1'b0; wr(3'd4, 8'h01);
        rd_chk(3'd4, 8'h21, "R9 top bit kept outside test mode");
        test_mode = 1'b1; wr(3'd4, 8'h01); test_mode = 1'b0;
        rd_chk(3'd4, 8'h01, "R9 top bit cleared in test mode");
        rd_chk(3'd2, 8'h34, "R9 ptr lo");
        rd_chk(3'd3, 8'h12, "R9 ptr mid");

        // R2 key register reads zero
        wr(3'd1, 8'h55);
        rd_chk(3'd1, 8'h00, "R2 key reads zero");

        // R10 select bits
        wr(3'd0, 8'h49);
        rd_chk(3'd0, 8'h49, "R10 ctrl readback");
        probe(K_ERASE, 1, "R10 erase output");
        probe(K_PROG, 1, "R10 program space output");

        // R3 happy path, R12 writes blocked, R6 done handshake
        unlock_go(8'h4B);
        probe(K_STALL, 1, "R3 stall after unlock");
        probe(K_WRREQ, 1, "R3 write request");
        probe(K_ADDR, 32'h011234, "R3 address");
        wr(3'd2, 8'h99);
        wr(3'd0, 8'h00);
        probe(K_STALL, 1, "R6 stall held before done");
        pulse_done();
        probe(K_STALL, 0, "R6 stall released after done");
        rd_chk(3'd0, 8'h49, "R12 ctrl untouched while busy, R6 go cleared");
        rd_chk(3'd2, 8'h34, "R12 ptr untouched while busy");

        // R4 disarm cases
        wr(3'd1, 8'hAA); wr(3'd1, 8'h55); wr(3'd0, 8'h4B);
        probe(K_STALL, 0, "R4 reversed key");
        wr(3'd1, 8'h55); rd_chk(3'd0, 8'h49, "R4 ctrl read mid key");
        wr(3'd1, 8'hAA); wr(3'd0, 8'h4B);
        probe(K_STALL, 0, "R4 read between key bytes");
        wr(3'd1, 8'h55); wr(3'd1, 8'hAA); rd_chk(3'd2, 8'h34, "R4 ptr read after key");
        wr(3'd0, 8'h4B);
        probe(K_STALL, 0, "R4 read before start");
        wr(3'd1, 8'h55); wr(3'd1, 8'h55); wr(3'd1, 8'hAA); wr(3'd0, 8'h4B);
        probe(K_STALL, 0, "R4 repeated first byte");

        // R5 enable clear
        wr(3'd0, 8'h48);
        unlock_go(8'h4B);
        probe(K_STALL, 0, "R5 start ignored with enable clear");
        wr(3'd0, 8'h4B);
        probe(K_STALL, 0, "R5 sequence dropped");
        rd_chk(3'd0, 8'h49, "R5 ctrl after refused start");

        // R7 abort by master clear
        unlock_go(8'h4B);
        probe(K_STALL, 1, "R7 write running");
        pulse_mclr();
        probe(K_STALL, 0, "R7 stall cleared by abort");
        rd_chk(3'd0, 8'h10, "R7 error flag set");
        rd_chk(3'd2, 8'h00, "R7 pointer cleared");
        pulse_wdt();
        rd_chk(3'd0, 8'h10, "R7 error survives warm reset");

        // R8 clearing rules
        wr(3'd0, 8'h11);
        rd_chk(3'd0, 8'h11, "R8 write of one keeps flag");
        wr(3'd0, 8'h01);
        rd_chk(3'd0, 8'h01, "R8 write of zero clears flag");
        wr(3'd0, 8'h11);
        rd_chk(3'd0, 8'h01, "R8 write of one does not set flag");
        unlock_go(8'h03);
        probe(K_STALL, 1, "R7 second write running");
        pulse_wdt();
        rd_chk(3'd0, 8'h10, "R7 watchdog abort sets flag");
        do_por();
        rd_chk(3'd0, 8'h00, "R8 power-on reset clears flag");

        // R11 read request pulse
        wr(3'd0, 8'h04);
        probe(K_RDREQ, 1, "R11 read request high");
        probe(K_RDREQ, 0, "R11 read request one cycle");
        rd_chk(3'd0, 8'h00, "R11 read bit reads zero");
        probe(K_STALL, 0, "R11 no write from read");

        repeat (2) @(posedge clk);
        done = 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (done) begin
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end else if (cycles > 20000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule